// File: doc/BRIEF.md
# Eight-Level Masked Interrupt Prioritizer

This block sits beside a processor core and decides which interrupt, if any, the core should take next. It watches a set of level-sensitive maskable sources. Each source has its own enable bit and its own 3-bit priority. It also watches one non-maskable input. Among the enabled requests it picks the one with the highest priority and compares that priority with a 3-bit mask level held in an extended status register.

A request whose level is strictly greater than the mask is taken, but only on a cycle where the core signals that an instruction has just completed. Taking a request does three things: it posts a vector number to the core, raises the mask to the level that was taken, and clears the trace bit. The vector stays posted until the core acknowledges it.

Saving the program counter and status, fetching the vector table and the pipeline are all outside the block. They appear only as the vector/acknowledge handshake. The core can also overwrite the mask and trace bits through a small write port.

Top module: `prio_irq_mask_ctrl`

## Requirements
- R1: After reset the mask level reads 7, the trace bit reads 0 and no vector is posted.
- R2: A maskable source whose enable bit is 0 is never taken, whatever its level.
- R3: Among enabled requesting sources, the one with the highest 3-bit level is the one taken.
- R4: When several enabled requests share the highest level, the one with the lowest source index is taken.
- R5: A request whose level is equal to or below the mask is not taken. It is not lost: it is taken once the mask drops below its level, provided it is still asserted.
- R6: A request is taken only on a rising clock edge where the instruction-done input is 1.
- R7: On the edge that takes a maskable request, the mask becomes that request's level and the trace bit becomes 0.
- R8: The posted vector number is 16 plus the source index for maskable source i. For the non-maskable input it is 7.
- R9: A rising edge on the non-maskable input is latched. It is taken regardless of enables and mask, it outranks every maskable source, and taking it sets the mask to 7. A held-high input does not cause a second take.
- R10: While a vector is posted and not yet acknowledged, the vector stays unchanged and no other request is taken. The first edge with acknowledge high clears the posting.
- R11: A register write sets the mask and trace bits from the edge at which the write is strobed. On an edge that also takes a request, the take's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 16 | Level-sensitive request per maskable source |
| src_en | input | 16 | Enable bit per maskable source |
| src_lvl | input | 48 | 3-bit priority per source, source i in bits [3i+2:3i] |
| nmi_in | input | 1 | Non-maskable request, rising edge latched |
| insn_done | input | 1 | High on a cycle where the current instruction completes |
| vec_ack | input | 1 | Core accepts the posted vector |
| csr_we | input | 1 | Write strobe for mask and trace bits |
| csr_mask_wr | input | 3 | Mask level to write |
| csr_trace_wr | input | 1 | Trace bit to write |
| mask_lvl | output | 3 | Current interrupt mask level |
| trace_bit | output | 1 | Current trace bit |
| vec_valid | output | 1 | A vector is posted and awaiting acknowledge |
| vec_num | output | 8 | Posted vector number |

## Verification
The selection is tried with three patterns:
- a mix of distinct levels, where only the maximum should win;
- three sources tied at one level, which shows whether the tie-break runs low-to-high or high-to-low;
- a source held at exactly the mask level, which separates a strict comparison from a non-strict one and shows that the request survives until the mask is lowered.

Further runs check the control path:
- disabled sources;
- requests arriving without an instruction-done strobe;
- a higher request arriving while a vector is still unacknowledged;
- a non-maskable edge racing a level-7 maskable source;
- a register write landing on the same edge as a take.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int LVL_W = 3;
    localparam int VEC_W = 8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    localparam lvl_t LVL_TOP = '1;
    localparam vec_t NMI_VEC = vec_t'(7);

    typedef struct packed {
        logic  valid;
        logic  is_nmi;
        lvl_t  lvl;
        vec_t  vec;
    } cand_t;

    typedef enum logic {
        ST_IDLE,
        ST_POSTED
    } post_state_t;

    function automatic vec_t src_vector(input int base, input int idx);
        return vec_t'(base + idx);
    endfunction

endpackage

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int VEC_BASE = 16
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC-1:0]       en,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
    output cand_t                    best
);

    logic [NUM_SRC-1:0] active;
    lvl_t               lvls [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign active[g] = req[g] & en[g];
        assign lvls[g]   = lvl_flat[g*LVL_W +: LVL_W];
    end

    // Scan from the top index down; ">=" lets a lower index replace an equal level.
    always_comb begin
        best = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i] && (!best.valid || lvls[i] >= best.lvl)) begin
                best.valid  = 1'b1;
                best.is_nmi = 1'b0;
                best.lvl    = lvls[i];
                best.vec    = src_vector(VEC_BASE, i);
            end
        end
    end

    always_comb begin
        if (best.valid) begin
            // R2
            sel_active_chk: assert (active[int'(best.vec) - VEC_BASE]);
            for (int k = 0; k < NUM_SRC; k++) begin
                // R3
                sel_max_chk: assert (!active[k] || lvls[k] <= best.lvl);
            end
        end else begin
            // R2
            sel_none_chk: assert (active == '0);
        end
    end

endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic clear,
    output logic pending
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            prev_q  <= nmi_in;
            pending <= (pending & ~clear) | (nmi_in & ~prev_q);
        end
    end

    // R9
    nmi_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_in && !prev_q) |=> pending);

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_prio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cand_t mbest,
    input  logic  nmi_pend,
    input  logic  insn_done,
    input  logic  vec_ack,
    input  logic  csr_we,
    input  lvl_t  csr_mask_wr,
    input  logic  csr_trace_wr,
    output logic  nmi_clear,
    output lvl_t  mask_lvl,
    output logic  trace_bit,
    output logic  vec_valid,
    output vec_t  vec_num
);

    post_state_t state_q;
    cand_t       win;
    logic        above_mask;
    logic        take;

    always_comb begin
        if (nmi_pend) begin
            win.valid  = 1'b1;
            win.is_nmi = 1'b1;
            win.lvl    = LVL_TOP;
            win.vec    = NMI_VEC;
        end else begin
            win = mbest;
        end
    end

    assign above_mask = win.valid && (win.is_nmi || win.lvl > mask_lvl);
    assign take       = (state_q == ST_IDLE) && insn_done && above_mask;
    assign nmi_clear  = take && win.is_nmi;
    assign vec_valid  = (state_q == ST_POSTED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mask_lvl  <= LVL_TOP;
            trace_bit <= 1'b0;
            vec_num   <= '0;
        end else if (take) begin
            state_q   <= ST_POSTED;
            vec_num   <= win.vec;
            mask_lvl  <= win.is_nmi ? LVL_TOP : win.lvl;
            trace_bit <= 1'b0;
        end else begin
            if (csr_we) begin
                mask_lvl  <= csr_mask_wr;
                trace_bit <= csr_trace_wr;
            end
            if (state_q == ST_POSTED && vec_ack) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // R6
    take_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!vec_valid && !insn_done) |=> !vec_valid);

    // R7
    trace_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> !trace_bit);

    // R5
    strict_above_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(vec_valid) && vec_num != NMI_VEC) |-> mask_lvl > $past(mask_lvl));

    // R9
    nmi_mask_top_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(vec_valid) && vec_num == NMI_VEC) |-> mask_lvl == LVL_TOP);

    // R10
    posted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ack) |=> (vec_valid && $stable(vec_num)));

    // R10
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_ack) |=> !vec_valid);

endmodule

// File: rtl/prio_irq_mask_ctrl.sv
module prio_irq_mask_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int VEC_BASE = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
    input  logic                     nmi_in,
    input  logic                     insn_done,
    input  logic                     vec_ack,
    input  logic                     csr_we,
    input  logic [LVL_W-1:0]         csr_mask_wr,
    input  logic                     csr_trace_wr,
    output logic [LVL_W-1:0]         mask_lvl,
    output logic                     trace_bit,
    output logic                     vec_valid,
    output logic [VEC_W-1:0]         vec_num
);

    cand_t mbest;
    logic  nmi_pend;
    logic  nmi_clear;

    irq_level_arbiter #(
        .NUM_SRC  (NUM_SRC),
        .VEC_BASE (VEC_BASE)
    ) u_arb (
        .req      (src_req),
        .en       (src_en),
        .lvl_flat (src_lvl),
        .best     (mbest)
    );

    irq_nmi_edge u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_in  (nmi_in),
        .clear   (nmi_clear),
        .pending (nmi_pend)
    );

    irq_accept_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .mbest        (mbest),
        .nmi_pend     (nmi_pend),
        .insn_done    (insn_done),
        .vec_ack      (vec_ack),
        .csr_we       (csr_we),
        .csr_mask_wr  (csr_mask_wr),
        .csr_trace_wr (csr_trace_wr),
        .nmi_clear    (nmi_clear),
        .mask_lvl     (mask_lvl),
        .trace_bit    (trace_bit),
        .vec_valid    (vec_valid),
        .vec_num      (vec_num)
    );

endmodule

// File: tb/prio_irq_mask_ctrl_test.sv
module prio_irq_mask_ctrl_test;

    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_req = '0;
    logic [N-1:0]  src_en  = '0;
    logic [N*3-1:0] src_lvl = '0;
    logic          nmi_in = 1'b0;
    logic          insn_done = 1'b0;
    logic          vec_ack = 1'b0;
    logic          csr_we = 1'b0;
    logic [2:0]    csr_mask_wr = '0;
    logic          csr_trace_wr = 1'b0;
    logic [2:0]    mask_lvl;
    logic          trace_bit;
    logic          vec_valid;
    logic [7:0]    vec_num;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    prio_irq_mask_ctrl uut (
        .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
        .src_lvl(src_lvl), .nmi_in(nmi_in), .insn_done(insn_done),
        .vec_ack(vec_ack), .csr_we(csr_we), .csr_mask_wr(csr_mask_wr),
        .csr_trace_wr(csr_trace_wr), .mask_lvl(mask_lvl),
        .trace_bit(trace_bit), .vec_valid(vec_valid), .vec_num(vec_num)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_src(input int idx, input int lv, input bit r, input bit e);
        src_lvl[idx*3 +: 3] = 3'(lv);
        src_req[idx] = r;
        src_en[idx]  = e;
    endtask

    task automatic clear_all();
        src_req = '0; src_en = '0; src_lvl = '0; insn_done = 1'b0;
    endtask

    task automatic write_csr(input int m, input bit t);
        csr_we = 1'b1; csr_mask_wr = 3'(m); csr_trace_wr = t;
        tick();
        csr_we = 1'b0;
    endtask

    task automatic do_ack();
        insn_done = 1'b0;
        vec_ack = 1'b1;
        tick();
        vec_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mask", mask_lvl, 7);
        chk("R1 trace", trace_bit, 0);
        chk("R1 valid", vec_valid, 0);
    endtask

    task automatic t_csr();
        write_csr(0, 1'b1);
        chk("R11 mask write", mask_lvl, 0);
        chk("R11 trace write", trace_bit, 1);
    endtask

    task automatic t_enable_boundary();
        set_src(3, 5, 1'b1, 1'b0);
        insn_done = 1'b1;
        tick();
        chk("R2 disabled not taken", vec_valid, 0);
        insn_done = 1'b0;
        src_en[3] = 1'b1;
        tick();
        chk("R6 no take without boundary", vec_valid, 0);
        insn_done = 1'b1;
        tick();
        chk("R6 take at boundary", vec_valid, 1);
        chk("R8 vector src3", vec_num, 19);
        chk("R7 mask to level", mask_lvl, 5);
        chk("R7 trace cleared", trace_bit, 0);
        do_ack();
        chk("R10 ack clears", vec_valid, 0);
        clear_all();
    endtask

    task automatic t_highest();
        write_csr(0, 1'b0);
        set_src(2, 3, 1'b1, 1'b1);
        set_src(9, 6, 1'b1, 1'b1);
        set_src(12, 4, 1'b1, 1'b1);
        insn_done = 1'b1;
        tick();
        chk("R3 highest vector", vec_num, 25);
        chk("R3 mask level", mask_lvl, 6);
        do_ack();
        insn_done = 1'b1;
        tick();
        chk("R5 equal level held", vec_valid, 0);
        insn_done = 1'b0;
        write_csr(3, 1'b0);
        insn_done = 1'b1;
        tick();
        chk("R5 pending taken later", vec_valid, 1);
        chk("R5 pending vector", vec_num, 25);
        do_ack();
        clear_all();
    endtask

    task automatic t_tie();
        write_csr(0, 1'b0);
        set_src(14, 4, 1'b1, 1'b1);
        set_src(10, 4, 1'b1, 1'b1);
        set_src(5, 4, 1'b1, 1'b1);
        insn_done = 1'b1;
        tick();
        chk("R4 lowest index wins", vec_num, 21);
        do_ack();
        clear_all();
    endtask

    task automatic t_hold();
        write_csr(0, 1'b0);
        set_src(4, 2, 1'b1, 1'b1);
        insn_done = 1'b1;
        tick();
        chk("R8 vector src4", vec_num, 20);
        set_src(11, 7, 1'b1, 1'b1);
        for (int k = 0; k < 3; k++) tick();
        chk("R10 vector held", vec_num, 20);
        chk("R10 still posted", vec_valid, 1);
        vec_ack = 1'b1;
        tick();
        vec_ack = 1'b0;
        chk("R10 released", vec_valid, 0);
        tick();
        chk("R10 next take", vec_num, 27);
        chk("R7 mask after next", mask_lvl, 7);
        do_ack();
        clear_all();
    endtask

    task automatic t_nmi();
        write_csr(0, 1'b0);
        set_src(0, 7, 1'b1, 1'b1);
        nmi_in = 1'b1;
        tick();
        insn_done = 1'b1;
        tick();
        chk("R9 nmi outranks", vec_num, 7);
        chk("R9 mask forced", mask_lvl, 7);
        do_ack();
        insn_done = 1'b1;
        tick();
        chk("R9 held nmi no retake", vec_valid, 0);
        nmi_in = 1'b0;
        clear_all();
    endtask

    task automatic t_csr_race();
        write_csr(0, 1'b0);
        set_src(1, 2, 1'b1, 1'b1);
        insn_done = 1'b1;
        csr_we = 1'b1; csr_mask_wr = 3'd1; csr_trace_wr = 1'b1;
        tick();
        csr_we = 1'b0;
        chk("R11 take wins mask", mask_lvl, 2);
        chk("R11 take wins trace", trace_bit, 0);
        chk("R8 vector src1", vec_num, 17);
        do_ack();
        clear_all();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_csr();
        t_enable_boundary();
        t_highest();
        t_tie();
        t_hold();
        t_nmi();
        t_csr_race();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule